// File: doc/BRIEF.md
# Shared-Period Match PWM Generator

This block turns one free-running count into six pulse-width-modulated outputs that all share a single period. A prescaler divides the clock into count ticks. A counter advances on each tick and wraps to zero after it reaches the period value held in match slot 0. Six more match slots set the edges of the outputs.

Each output runs in one of two modes. In single-edge mode it rises at every wrap and falls on its own match. In double-edge mode it takes both edges from two neighbouring match slots.

Match values pass through a shadow copy, so a new value takes effect only at the next wrap and a pulse is never cut short. Every match also sets a sticky flag. The flags are ORed into one interrupt line. A simple synchronous write / combinational read register port gives access to the control, mode, prescale, counter, flag and match registers.

Top module: `pwm_match_unit`

## Requirements
- R1: After reset, every output is low, `irq` is low, and the counter (address 3) and the flag register (address 4) read 0.
- R2: When the control register (address 0) has bit 0 = 1 (run) and bit 1 = 0 (hold), the counter advances once every PRESC+1 clocks. PRESC is the prescale register at address 2. When run is 0, the counter holds its value.
- R3: On a tick where the counter equals the period shadow (match slot 0, address 8), the counter returns to 0. On any other tick it increments by one. One period is therefore slot-0 value + 1 ticks.
- R4: In single-edge mode, output k (`pwm_out[k]`, k = 0..5) goes high at every wrap, together with every other single-edge output. It goes low on the tick where the counter equals its match slot k+1 (address 9+k), so it stays high for that value + 1 ticks.
- R5: When bit k of the mode register (address 1) is 1, with k = 1..5, output k is double-edge. It is set on the tick that matches slot k and cleared on the tick that matches slot k+1. If both match on the same tick, clearing wins. Bit 0 is ignored, so output 0 is always single-edge.
- R6: A write to a match slot (addresses 8..14) changes the compare value only after the next wrap, or at once while hold is set.
- R7: In single-edge mode, a match value larger than the period keeps the output high for the whole cycle, and a match value of 0 keeps it low for the whole cycle.
- R8: Flag i (bit i at address 4) sets on each tick where the counter equals shadow slot i. Writing 1 to a bit clears it; a new match wins over a clear in the same cycle. `irq` is the OR of all flags.
- R9: While hold (control bit 1) is set, the counter and the prescaler stay at 0, all outputs are low, and the shadows track the written match values.
- R10: A write to address 3 loads the counter, restarts the prescale count, and suppresses the tick in that cycle.
- R11: The control, mode, prescale and match registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_OUT | PWM outputs |
| irq | output | 1 | OR of all match flags |

## Verification
A bad counter or prescaler state changes the value read at address 3 in the very next cycle. It also shifts every output edge within one period. A stale or early shadow value moves a falling edge in the cycle right after the write, when it should move only after the next wrap, so the bench watches that window clock by clock. A wrong flag shows on `irq` one clock after the tick that should have set it or left it clear.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_PRESC  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MATCH0 = 4'd8;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_HOLD_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_match_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 6,
  localparam int NUM_MATCH = NUM_OUT + 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_we,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [CNT_W-1:0]                     bus_wdata,
  output logic [CNT_W-1:0]                     bus_rdata,
  input  logic [CNT_W-1:0]                     cnt,
  input  logic [NUM_MATCH-1:0]                 match_evt,
  output logic                                 run,
  output logic                                 hold,
  output logic [NUM_OUT-1:0]                   mode,
  output logic [CNT_W-1:0]                     presc,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]      live,
  output logic                                 cnt_ld,
  output logic [NUM_MATCH-1:0]                 flags,
  output logic                                 irq
);
  logic                            run_q, run_d, hold_q, hold_d;
  logic [NUM_OUT-1:0]              mode_q, mode_d;
  logic [CNT_W-1:0]                presc_q, presc_d;
  logic [NUM_MATCH-1:0][CNT_W-1:0] live_q, live_d;
  logic [NUM_MATCH-1:0]            flags_q, flags_d;

  always_comb begin
    run_d   = run_q;
    hold_d  = hold_q;
    mode_d  = mode_q;
    presc_d = presc_q;
    live_d  = live_q;
    flags_d = flags_q;
    if (bus_we) begin
      if (bus_addr == ADR_CTRL) begin
        run_d  = bus_wdata[CTRL_RUN_BIT];
        hold_d = bus_wdata[CTRL_HOLD_BIT];
      end
      if (bus_addr == ADR_MODE)  mode_d  = bus_wdata[NUM_OUT-1:0];
      if (bus_addr == ADR_PRESC) presc_d = bus_wdata;
      if (bus_addr == ADR_FLAGS) flags_d = flags_q & ~bus_wdata[NUM_MATCH-1:0];
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (bus_addr == ADR_MATCH0 + ADDR_W'(i)) live_d[i] = bus_wdata;
      end
    end
    flags_d = flags_d | match_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      mode_q  <= '0;
      presc_q <= '0;
      live_q  <= '0;
      flags_q <= '0;
    end else begin
      run_q   <= run_d;
      hold_q  <= hold_d;
      mode_q  <= mode_d;
      presc_q <= presc_d;
      live_q  <= live_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]  = run_q;
        bus_rdata[CTRL_HOLD_BIT] = hold_q;
      end
      ADR_MODE:  bus_rdata[NUM_OUT-1:0]   = mode_q;
      ADR_PRESC: bus_rdata                = presc_q;
      ADR_COUNT: bus_rdata                = cnt;
      ADR_FLAGS: bus_rdata[NUM_MATCH-1:0] = flags_q;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++) begin
          if (bus_addr == ADR_MATCH0 + ADDR_W'(i)) bus_rdata = live_q[i];
        end
      end
    endcase
  end

  assign run    = run_q;
  assign hold   = hold_q;
  assign mode   = mode_q;
  assign presc  = presc_q;
  assign live   = live_q;
  assign cnt_ld = bus_we && (bus_addr == ADR_COUNT);
  assign flags  = flags_q;
  assign irq    = |flags_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] presc,
  input  logic [CNT_W-1:0] period,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic [CNT_W-1:0] pc_q, pc_d, cnt_q, cnt_d;
  logic             pc_wrap;

  assign pc_wrap = (pc_q >= presc);
  assign tick    = run && !hold && !cnt_ld && pc_wrap;

  always_comb begin
    pc_d = pc_q;
    if (hold || cnt_ld)  pc_d = '0;
    else if (run)        pc_d = pc_wrap ? '0 : pc_q + 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (hold)        cnt_d = '0;
    else if (cnt_ld) cnt_d = ld_val;
    else if (tick)   cnt_d = (cnt_q == period) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            hold,
  input  logic                            tick,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] live,
  output logic [CNT_W-1:0]                period,
  output logic [NUM_MATCH-1:0]            match_evt
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] sh_q, sh_d;
  logic                            load;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign match_evt[i] = tick && (cnt == sh_q[i]);
  end

  assign load = hold || match_evt[0];

  always_comb begin
    sh_d = sh_q;
    if (load) sh_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign period = sh_q[0];
endmodule

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl #(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 6,
  localparam int NUM_MATCH = NUM_OUT + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            hold,
  input  logic [NUM_MATCH-1:0]            match_evt,
  input  logic [NUM_OUT-1:0]              mode,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] live,
  output logic [NUM_OUT-1:0]              pwm_out
);
  logic [NUM_OUT-1:0] out_q, out_d;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic dbl_en;
    logic nxt;
    if (k == 0) begin : g_fixed
      assign dbl_en = 1'b0;
    end else begin : g_sel
      assign dbl_en = mode[k];
    end
    always_comb begin
      nxt = out_q[k];
      if (hold) begin
        nxt = 1'b0;
      end else if (dbl_en) begin
        if (match_evt[k+1])    nxt = 1'b0;
        else if (match_evt[k]) nxt = 1'b1;
      end else if (match_evt[0]) begin
        nxt = |live[k+1];
      end else if (match_evt[k+1]) begin
        nxt = 1'b0;
      end
    end
    assign out_d[k] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit
  import pwm_match_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic [NUM_OUT-1:0] pwm_out,
  output logic               irq
);
  localparam int NUM_MATCH = NUM_OUT + 1;

  logic                            ctrl_run, ctrl_hold, cnt_ld, tick;
  logic [NUM_OUT-1:0]              mode;
  logic [CNT_W-1:0]                presc, period, cnt;
  logic [NUM_MATCH-1:0][CNT_W-1:0] live;
  logic [NUM_MATCH-1:0]            match_evt, flags;

  pwm_regs #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt),
    .match_evt(match_evt), .run(ctrl_run), .hold(ctrl_hold), .mode(mode),
    .presc(presc), .live(live), .cnt_ld(cnt_ld), .flags(flags), .irq(irq)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(ctrl_run), .hold(ctrl_hold),
    .presc(presc), .period(period), .cnt_ld(cnt_ld), .ld_val(bus_wdata),
    .cnt(cnt), .tick(tick)
  );

  pwm_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .hold(ctrl_hold), .tick(tick), .cnt(cnt),
    .live(live), .period(period), .match_evt(match_evt)
  );

  pwm_edge_ctrl #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_edge (
    .clk(clk), .rst_n(rst_n), .hold(ctrl_hold), .match_evt(match_evt),
    .mode(mode), .live(live), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_match_unit_chk.sv
module pwm_match_unit_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hold,
  input logic               run,
  input logic               cnt_ld,
  input logic               tick,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   period,
  input logic [NUM_OUT:0]   match_evt,
  input logic [NUM_OUT:0]   flags,
  input logic [NUM_OUT-1:0] pwm_out
);
  // R9: hold forces counter and outputs to zero
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0 && pwm_out == '0));

  // R2: a stopped counter keeps its value
  assert_stop_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !cnt_ld) |=> $stable(cnt));

  // R3: wrap on the period value
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == period) |=> cnt == '0);

  // R3: single step otherwise
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != period) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R8: period match sets flag 0
  assert_flag0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[0] |=> flags[0]);
endmodule

bind pwm_match_unit pwm_match_unit_chk #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(ctrl_hold), .run(ctrl_run), .cnt_ld(cnt_ld),
  .tick(tick), .cnt(cnt), .period(period), .match_evt(match_evt),
  .flags(flags), .pwm_out(pwm_out)
);

// File: tb/pwm_match_unit_bench.sv
module pwm_match_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_out;
  logic        irq;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  pwm_match_unit u_pwm_match_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements, evaluated per clock edge
  logic        r_run, r_hold, r_t, r_cw;
  logic [5:0]  r_mode, r_out, n_out;
  logic [6:0]  r_flags, r_m;
  logic [31:0] r_presc, r_pc, r_cnt;
  logic [31:0] r_live [7];
  logic [31:0] r_sh   [7];
  logic [38:0] exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      r_run = 0; r_hold = 0; r_mode = 0; r_out = 0; r_flags = 0;
      r_presc = 0; r_pc = 0; r_cnt = 0;
      for (int i = 0; i < 7; i++) begin r_live[i] = 0; r_sh[i] = 0; end
    end else begin
      r_cw = bus_we && bus_addr == 4'd3;
      r_t  = r_run && !r_hold && !r_cw && (r_pc >= r_presc);
      for (int i = 0; i < 7; i++) r_m[i] = r_t && (r_cnt == r_sh[i]);
      n_out = r_out;
      for (int k = 0; k < 6; k++) begin
        if (r_hold) n_out[k] = 1'b0;
        else if (k != 0 && r_mode[k]) begin
          if (r_m[k+1]) n_out[k] = 1'b0;
          else if (r_m[k]) n_out[k] = 1'b1;
        end else if (r_m[0]) n_out[k] = (r_live[k+1] != 0);
        else if (r_m[k+1]) n_out[k] = 1'b0;
      end
      r_out = n_out;
      if (r_hold || r_m[0]) for (int i = 0; i < 7; i++) r_sh[i] = r_live[i];
      if (r_hold) r_cnt = 0;
      else if (r_cw) r_cnt = bus_wdata;
      else if (r_t) r_cnt = (r_cnt == r_sh_old0()) ? 0 : r_cnt + 1;
      if (r_hold || r_cw) r_pc = 0;
      else if (r_run) r_pc = (r_pc >= r_presc) ? 0 : r_pc + 1;
      if (bus_we && bus_addr == 4'd4) r_flags = r_flags & ~bus_wdata[6:0];
      r_flags = r_flags | r_m;
      if (bus_we) begin
        case (bus_addr)
          4'd0: begin r_run = bus_wdata[0]; r_hold = bus_wdata[1]; end
          4'd1: r_mode = bus_wdata[5:0];
          4'd2: r_presc = bus_wdata;
          default: if (bus_addr >= 4'd8 && bus_addr <= 4'd14) r_live[bus_addr-8] = bus_wdata;
        endcase
      end
      exp_q.push_back({r_out, |r_flags, r_cnt});
    end
  end

  // period comparison must use the value that held before the shadow reload
  logic [31:0] sh0_prev;
  always @(posedge clk) sh0_prev <= r_sh[0];
  function automatic logic [31:0] r_sh_old0();
    return r_m[0] ? r_cnt : r_sh[0];
  endfunction

  // monitor: pops one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [38:0] e;
      e = exp_q.pop_front();
      chk({cur_tag, " out"}, {26'd0, pwm_out}, {26'd0, e[38:33]});
      chk({cur_tag, " irq"}, {31'd0, irq}, {31'd0, e[32]});
      if (bus_addr == 4'd3 && !bus_we) chk({cur_tag, " count"}, bus_rdata, e[31:0]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = 4'd3; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk); #1;
    d = bus_rdata;
    #1 bus_addr = 4'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 outputs", {26'd0, pwm_out}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd3, v); chk("R1 count", v, 32'd0);
    rd(4'd4, v); chk("R1 flags", v, 32'd0);

    // R11 / R9: configure under hold
    cur_tag = "R9";
    wr(4'd0, 32'd2);
    wr(4'd2, 32'd0);
    wr(4'd8, 32'd9);  wr(4'd9, 32'd3);  wr(4'd10, 32'd5);
    wr(4'd11, 32'd7); wr(4'd12, 32'd1); wr(4'd13, 32'd8); wr(4'd14, 32'd9);
    wr(4'd1, 32'd0);
    idle(4);
    cur_tag = "R11";
    rd(4'd0, v);  chk("R11 ctrl", v, 32'd2);
    rd(4'd8, v);  chk("R11 match0", v, 32'd9);
    rd(4'd11, v); chk("R11 match3", v, 32'd7);
    rd(4'd2, v);  chk("R11 presc", v, 32'd0);

    // R4 / R3: single-edge run
    cur_tag = "R4";
    wr(4'd0, 32'd1);
    idle(35);

    // R5: double-edge on outputs 1 and 2, bit 0 set but ignored
    cur_tag = "R5";
    wr(4'd1, 32'h07);
    rd(4'd1, v); chk("R11 mode", v, 32'h07);
    idle(30);

    // R6: mid-cycle match update
    cur_tag = "R6";
    wr(4'd10, 32'd8);
    idle(25);

    // R7: match above period and match of zero
    cur_tag = "R7";
    wr(4'd1, 32'd0);
    wr(4'd12, 32'd15);
    wr(4'd13, 32'd0);
    idle(30);
    @(negedge clk); chk("R7 steady levels", {30'd0, pwm_out[4:3]}, 32'd1);

    // R2: prescaler and stop
    cur_tag = "R2";
    wr(4'd2, 32'd2);
    idle(40);
    wr(4'd0, 32'd0);
    idle(6);
    rd(4'd3, v); idle(5); rd(4'd3, v2);
    chk("R2 stopped count", v2, v);

    // R10: counter load
    cur_tag = "R10";
    wr(4'd0, 32'd1);
    wr(4'd3, 32'd4);
    rd(4'd3, v); chk("R10 loaded count", v, 32'd4);
    idle(30);

    // R8: flag clear and re-set
    cur_tag = "R8";
    wr(4'd0, 32'd0);
    wr(4'd4, 32'h7F);
    rd(4'd4, v); chk("R8 cleared flags", v, 32'd0);
    @(negedge clk); chk("R8 irq low", {31'd0, irq}, 32'd0);
    wr(4'd2, 32'd0);
    wr(4'd0, 32'd1);
    idle(30);
    rd(4'd4, v); chk("R8 flags", v, 32'h6F);
    @(negedge clk); chk("R8 irq high", {31'd0, irq}, 32'd1);

    // R9: hold again
    cur_tag = "R9";
    wr(4'd0, 32'd3);
    idle(5);
    @(negedge clk); chk("R9 outputs low", {26'd0, pwm_out}, 32'd0);
    rd(4'd3, v); chk("R9 count zero", v, 32'd0);

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule